// File: doc/BRIEF.md
# Banked Data Cache Port Arbiter

This block steers up to four simultaneous load/store requests onto eight single-ported data SRAM banks. Consecutive 32-byte cache lines live in consecutive banks (line index modulo eight), so requests to nearby but distinct lines usually land in different banks and are all served in the same cycle. The block splits each request address into a bank number, a row inside the bank and a 32-bit word inside the line, then drives one enable, row, word select and write flag per bank.

When two or more live requests name the same bank, only one of them can reach that bank in a cycle. The block then holds the whole instruction with a global stall. In every stalled cycle each bank takes the lowest-numbered port still waiting for it. Ports already served are masked until every live request of the instruction has had its turn, and the stall drops in the cycle that serves the last one. The requester keeps its inputs unchanged while the stall is high and presents the next instruction in the cycle after the stall is low.

Top module: `dcache_bank_arbiter`

## Requirements
- R1: Address bits [7:5] (little-endian numbering, bit 0 the least significant) give the bank, bits [14:8] give the row and bits [4:2] give the word inside the line. The granted port's row and word appear on that bank's row and word outputs in the same cycle. All other address bits have no effect.
- R2: When no two live requests share a bank, every live request is granted in the cycle it is presented and stall stays low.
- R3: A port whose valid bit is low is never granted, never drives a bank and never causes a stall, even when its address collides with a live port.
- R4: Among live, not yet served requests to one bank, the port with the lowest number is granted first.
- R5: Each bank grants at most one port per cycle, and different banks are served in the same cycle. An instruction therefore takes as many cycles as the largest number of live requests aimed at a single bank.
- R6: Stall is high in exactly those cycles in which a live, not yet served request is left ungranted. A port granted during a stall is not granted again for that instruction. The served mask clears in the cycle after stall is low.
- R7: Requests with identical bank, row and word are still serialized one per cycle in port order.
- R8: A bank's enable is high only when a port is granted to it, and its write flag copies that port's read/write bit (1 = write). Idle banks drive zero on enable, row, word and write flag.
- R9: An asynchronous active-low reset clears the served mask, so the current requests are treated as a fresh instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| req_valid | input | 4 | Request live, one bit per port |
| req_addr | input | 4x32 | Byte address per port |
| req_we | input | 4 | 1 = store, 0 = load, per port |
| req_grant | output | 4 | Port is served by its bank this cycle |
| stall | output | 1 | Instruction still has waiting requests |
| bank_en | output | 8 | Bank access enable |
| bank_row | output | 8x7 | Row index per bank |
| bank_word | output | 8x3 | Word select per bank |
| bank_we | output | 8 | Write flag per bank |

## Verification
The assertions assume that the requester holds valid bits, addresses and write flags steady for as long as stall is high, and one of them checks exactly that. The bench presents a new instruction only at the falling edge after a cycle in which its own model predicts stall low, so every instruction meets this rule. The one deliberate break is a reset pulse in the middle of a stalled instruction, and the assertions are disabled while that reset is active. The stimulus mixes directed patterns (all ports on one bank, identical addresses, dead ports that collide with live ones, two pairs of conflicts) with random addresses whose banks are drawn from a small set, so that conflicts happen often.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  // default geometry of the banked data array
  localparam int unsigned DEF_PORTS      = 4;
  localparam int unsigned DEF_BANKS      = 8;
  localparam int unsigned DEF_ADDR_W     = 32;
  localparam int unsigned DEF_LINE_BYTES = 32;
  localparam int unsigned DEF_WORD_BYTES = 4;
  localparam int unsigned DEF_ROWS       = 128;

  // phase of the instruction currently presented
  typedef enum logic {
    PH_FRESH   = 1'b0,  // nothing served yet
    PH_SERVING = 1'b1   // part of the instruction already served
  } phase_e;
endpackage

// File: rtl/dcb_addr_split.sv
module dcb_addr_split #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned WORD_LSB = 2,
  parameter int unsigned WORD_W   = 3,
  parameter int unsigned BANK_W   = 3,
  parameter int unsigned ROW_W    = 7
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [WORD_W-1:0] word
);
  localparam int unsigned BANK_LSB = WORD_LSB + WORD_W;
  localparam int unsigned ROW_LSB  = BANK_LSB + BANK_W;
  localparam int unsigned TOP_LSB  = ROW_LSB + ROW_W;

  assign word = addr[BANK_LSB-1:WORD_LSB];
  assign bank = addr[ROW_LSB-1:BANK_LSB];
  assign row  = addr[TOP_LSB-1:ROW_LSB];

  // byte offset and tag bits play no part in steering
  logic unused_bits;
  assign unused_bits = ^{addr[ADDR_W-1:TOP_LSB], addr[WORD_LSB-1:0]};
endmodule

// File: rtl/dcb_bank_pick.sv
module dcb_bank_pick #(
  parameter int unsigned NPORTS = 4,
  parameter int unsigned NBANKS = 8,
  parameter int unsigned BANK_W = 3,
  parameter int unsigned ROW_W  = 7,
  parameter int unsigned WORD_W = 3
) (
  input  logic [NPORTS-1:0]             pending,
  input  logic [NPORTS-1:0][BANK_W-1:0] p_bank,
  input  logic [NPORTS-1:0][ROW_W-1:0]  p_row,
  input  logic [NPORTS-1:0][WORD_W-1:0] p_word,
  input  logic [NPORTS-1:0]             p_we,
  output logic [NPORTS-1:0]             grant,
  output logic [NBANKS-1:0]             b_en,
  output logic [NBANKS-1:0][ROW_W-1:0]  b_row,
  output logic [NBANKS-1:0][WORD_W-1:0] b_word,
  output logic [NBANKS-1:0]             b_we
);
  logic [NBANKS-1:0][NPORTS-1:0] bank_gnt;

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic              found;
    logic [NPORTS-1:0] sel_vec;
    logic [ROW_W-1:0]  sel_row;
    logic [WORD_W-1:0] sel_word;
    logic              sel_we;

    // lowest port number wins the bank
    always_comb begin
      found    = 1'b0;
      sel_vec  = '0;
      sel_row  = '0;
      sel_word = '0;
      sel_we   = 1'b0;
      for (int p = 0; p < NPORTS; p++) begin
        if (!found && pending[p] && (p_bank[p] == BANK_W'(b))) begin
          found      = 1'b1;
          sel_vec[p] = 1'b1;
          sel_row    = p_row[p];
          sel_word   = p_word[p];
          sel_we     = p_we[p];
        end
      end
    end

    assign bank_gnt[b] = sel_vec;
    assign b_en[b]     = found;
    assign b_row[b]    = sel_row;
    assign b_word[b]   = sel_word;
    assign b_we[b]     = sel_we;
  end

  always_comb begin
    grant = '0;
    for (int b = 0; b < NBANKS; b++) begin
      grant = grant | bank_gnt[b];
    end
  end
endmodule

// File: rtl/dcb_served_track.sv
module dcb_served_track
  import dcb_pkg::*;
#(
  parameter int unsigned NPORTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS-1:0] req_valid,
  input  logic [NPORTS-1:0] grant,
  output logic [NPORTS-1:0] pending,
  output logic              stall
);
  logic [NPORTS-1:0] done_q, done_d;
  phase_e            phase_q, phase_d;
  logic              upd_en;

  // next-state logic
  always_comb begin
    pending = req_valid & ~done_q;
    stall   = |(pending & ~grant);
    if (stall) begin
      done_d  = done_q | grant;
      phase_d = PH_SERVING;
    end else begin
      done_d  = '0;
      phase_d = PH_FRESH;
    end
    upd_en = stall || (phase_q == PH_SERVING);
  end

  // state registers with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= '0;
      phase_q <= PH_FRESH;
    end else if (upd_en) begin
      done_q  <= done_d;
      phase_q <= phase_d;
    end
  end

  // R4: a stalled cycle always makes progress
  p_progress_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (grant != '0));

  // R6: after a cycle without stall the whole request set is pending again
  p_fresh_after_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> (pending == req_valid));

  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    // R6: a port served inside a stall is not served twice
    p_no_regrant_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && grant[p]) |=> !grant[p]);
  end
endmodule

// File: rtl/dcache_bank_arbiter.sv
module dcache_bank_arbiter
  import dcb_pkg::*;
#(
  parameter int unsigned NPORTS     = DEF_PORTS,
  parameter int unsigned NBANKS     = DEF_BANKS,
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned LINE_BYTES = DEF_LINE_BYTES,
  parameter int unsigned WORD_BYTES = DEF_WORD_BYTES,
  parameter int unsigned ROWS       = DEF_ROWS,
  localparam int unsigned ROW_W     = $clog2(ROWS),
  localparam int unsigned WORD_W    = $clog2(LINE_BYTES / WORD_BYTES)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NPORTS-1:0]                req_valid,
  input  logic [NPORTS-1:0][ADDR_W-1:0]    req_addr,
  input  logic [NPORTS-1:0]                req_we,
  output logic [NPORTS-1:0]                req_grant,
  output logic                             stall,
  output logic [NBANKS-1:0]                bank_en,
  output logic [NBANKS-1:0][ROW_W-1:0]     bank_row,
  output logic [NBANKS-1:0][WORD_W-1:0]    bank_word,
  output logic [NBANKS-1:0]                bank_we
);
  localparam int unsigned WORD_LSB = $clog2(WORD_BYTES);
  localparam int unsigned BANK_W   = $clog2(NBANKS);

  logic [NPORTS-1:0][BANK_W-1:0] dec_bank;
  logic [NPORTS-1:0][ROW_W-1:0]  dec_row;
  logic [NPORTS-1:0][WORD_W-1:0] dec_word;
  logic [NPORTS-1:0]             pending;

  for (genvar p = 0; p < NPORTS; p++) begin : g_dec
    dcb_addr_split #(
      .ADDR_W  (ADDR_W),
      .WORD_LSB(WORD_LSB),
      .WORD_W  (WORD_W),
      .BANK_W  (BANK_W),
      .ROW_W   (ROW_W)
    ) u_split (
      .addr(req_addr[p]),
      .bank(dec_bank[p]),
      .row (dec_row[p]),
      .word(dec_word[p])
    );
  end

  dcb_bank_pick #(
    .NPORTS(NPORTS),
    .NBANKS(NBANKS),
    .BANK_W(BANK_W),
    .ROW_W (ROW_W),
    .WORD_W(WORD_W)
  ) u_pick (
    .pending(pending),
    .p_bank (dec_bank),
    .p_row  (dec_row),
    .p_word (dec_word),
    .p_we   (req_we),
    .grant  (req_grant),
    .b_en   (bank_en),
    .b_row  (bank_row),
    .b_word (bank_word),
    .b_we   (bank_we)
  );

  dcb_served_track #(
    .NPORTS(NPORTS)
  ) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .grant    (req_grant),
    .pending  (pending),
    .stall    (stall)
  );

  // R6: requester holds the instruction while stalled (input rule)
  p_hold_inputs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(req_valid) && $stable(req_addr) && $stable(req_we)));

  // R3: dead ports never reach a bank
  p_grant_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_grant & ~req_valid) == '0);

  // R8: one enabled bank per granted port
  p_en_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(req_grant) == $countones(bank_en));

  for (genvar b = 0; b < NBANKS; b++) begin : g_bchk
    logic [NPORTS-1:0] hits;
    always_comb begin
      for (int p = 0; p < NPORTS; p++) begin
        hits[p] = req_grant[p] && (dec_bank[p] == BANK_W'(b));
      end
    end
    // R5: at most one port per bank per cycle
    p_bank_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hits));
  end

  for (genvar hi = 1; hi < NPORTS; hi++) begin : g_pri
    for (genvar lo = 0; lo < hi; lo++) begin : g_lo
      // R4: a higher port never overtakes a waiting lower port on the same bank
      p_low_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pending[lo] && pending[hi] && (dec_bank[lo] == dec_bank[hi]))
          |-> !req_grant[hi]);
    end
  end
endmodule

// File: tb/dcache_bank_arbiter_tb.sv
module dcache_bank_arbiter_tb_top;
  localparam int NP = 4;
  localparam int NB = 8;

  logic                  clk;
  logic                  rst_n;
  logic [NP-1:0]         v, w;
  logic [NP-1:0][31:0]   a;
  logic [NP-1:0]         req_grant;
  logic                  stall;
  logic [NB-1:0]         bank_en, bank_we;
  logic [NB-1:0][6:0]    bank_row;
  logic [NB-1:0][2:0]    bank_word;

  int n_chk  = 0;
  int n_fail = 0;
  logic [NP-1:0] m_served;
  logic          m_stall;

  dcache_bank_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(v), .req_addr(a), .req_we(w),
    .req_grant(req_grant), .stall(stall), .bank_en(bank_en),
    .bank_row(bank_row), .bank_word(bank_word), .bank_we(bank_we)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int bank, input int row, input int word);
    logic [31:0] r;
    r = $urandom;
    r[14:8] = row[6:0];
    r[7:5]  = bank[2:0];
    r[4:2]  = word[2:0];
    return r;
  endfunction

  // reference model for one cycle; compares and advances the served set
  task automatic cycle_check();
    logic [NP-1:0]      eg;
    bit                 taken [NB];
    logic [NB-1:0]      een, ewe;
    logic [NB-1:0][6:0] erow;
    logic [NB-1:0][2:0] eword;
    bit                 es;
    eg = '0; een = '0; ewe = '0; erow = '0; eword = '0;
    foreach (taken[i]) taken[i] = 0;
    for (int p = 0; p < NP; p++) begin
      int bk;
      bk = int'(a[p][7:5]);
      if (v[p] && !m_served[p] && !taken[bk]) begin
        taken[bk] = 1;
        eg[p]     = 1'b1;
        een[bk]   = 1'b1;
        ewe[bk]   = w[p];
        erow[bk]  = a[p][14:8];
        eword[bk] = a[p][4:2];
      end
    end
    es = ((v & ~m_served & ~eg) != '0);
    chk(req_grant == eg, "R4", "grant", req_grant, eg);
    chk(stall == es, "R6", "stall", stall, es);
    if (v != '1) chk((req_grant & ~v) == '0, "R3", "dead port grant", req_grant & ~v, 0);
    chk(bank_row == erow, "R1", "bank_row", bank_row, erow);
    chk(bank_word == eword, "R1", "bank_word", bank_word, eword);
    chk(bank_en == een, "R8", "bank_en", bank_en, een);
    chk(bank_we == ewe, "R8", "bank_we", bank_we, ewe);
    if (!rst_n) m_served = '0;
    else        m_served = es ? (m_served | eg) : '0;
    m_stall = es;
  endtask

  task automatic run_instr(input logic [NP-1:0] vv, input logic [NP-1:0][31:0] aa,
                           input logic [NP-1:0] ww, input string tag);
    int cnt [NB];
    int expc, cyc;
    v = vv; a = aa; w = ww;
    foreach (cnt[i]) cnt[i] = 0;
    expc = 1;
    for (int p = 0; p < NP; p++) begin
      if (vv[p]) begin
        cnt[aa[p][7:5]]++;
        if (cnt[aa[p][7:5]] > expc) expc = cnt[aa[p][7:5]];
      end
    end
    cyc = 0;
    do begin
      #1;
      cycle_check();
      cyc++;
      @(negedge clk);
    end while (m_stall);
    chk(cyc == expc, tag, "instruction cycles", cyc, expc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [NP-1:0][31:0] aa;
    rst_n = 1'b0; v = '0; w = '0; a = '0; m_served = '0; m_stall = 1'b0;
    #5;
    // R9: reset state with nothing live
    chk(stall == 1'b0, "R9", "stall in reset", stall, 0);
    chk(req_grant == '0, "R9", "grant in reset", req_grant, 0);
    chk(bank_en == '0, "R9", "bank_en in reset", bank_en, 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;

    // R2: four distinct banks
    aa[0] = mk(0, 5, 1); aa[1] = mk(3, 9, 7); aa[2] = mk(5, 127, 0); aa[3] = mk(7, 0, 4);
    run_instr(4'b1111, aa, 4'b1010, "R2");
    // R5: all four on one bank
    aa[0] = mk(2, 1, 0); aa[1] = mk(2, 2, 1); aa[2] = mk(2, 3, 2); aa[3] = mk(2, 4, 3);
    run_instr(4'b1111, aa, 4'b0110, "R5");
    // R7: identical bank, row and word on all ports
    aa[0] = mk(4, 33, 6); aa[1] = aa[0]; aa[2] = aa[0]; aa[3] = aa[0];
    run_instr(4'b1111, aa, 4'b1001, "R7");
    // R3: dead ports colliding with a live one
    aa[0] = mk(1, 7, 2); aa[1] = mk(1, 8, 2); aa[2] = mk(6, 8, 2); aa[3] = mk(1, 9, 5);
    run_instr(4'b0101, aa, 4'b1111, "R3");
    run_instr(4'b0000, aa, 4'b1111, "R3");
    // R5: two pairs of conflicts served side by side
    aa[0] = mk(1, 10, 0); aa[1] = mk(4, 11, 1); aa[2] = mk(1, 12, 2); aa[3] = mk(4, 13, 3);
    run_instr(4'b1111, aa, 4'b0011, "R5");

    // R9: reset in the middle of a stalled instruction
    aa[0] = mk(6, 20, 0); aa[1] = mk(6, 21, 1); aa[2] = mk(6, 22, 2); aa[3] = mk(6, 23, 3);
    v = 4'b1111; a = aa; w = 4'b0000;
    #1 cycle_check();
    @(negedge clk);
    #1 cycle_check();
    rst_n = 1'b0;
    #1;
    m_served = '0;
    chk(req_grant == 4'b0001, "R9", "grant after reset", req_grant, 4'b0001);
    chk(stall == 1'b1, "R9", "stall after reset", stall, 1);
    @(negedge clk);
    rst_n = 1'b1;
    do begin
      #1 cycle_check();
      @(negedge clk);
    end while (m_stall);

    // random instructions, banks drawn from a narrow set to force conflicts
    for (int n = 0; n < 300; n++) begin
      logic [NP-1:0] rv, rw;
      int span;
      span = (n % 3 == 0) ? 8 : 3;
      for (int p = 0; p < NP; p++) aa[p] = mk($urandom % span, $urandom % 128, $urandom % 8);
      rv = 4'($urandom);
      rw = 4'($urandom);
      run_instr(rv, aa, rw, "R5");
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule